// File: doc/BRIEF.md
# Fractional-Rate Serial Pattern Generator

This block plays a short bit pattern out on one serial output, over and over, at an average bit rate set as a fraction of the system clock. A phase accumulator with a fixed-point increment adds once per clock. Each time the accumulator carries past one whole unit, the generator moves to the next pattern bit. When the increment is an exact divisor of one unit, bit edges fall on a fixed grid of clock cycles. A fractional increment keeps the long-run rate accurate, but individual edges can arrive one clock early or late.

The pattern sits in a circular shift register. On each advance, only the active top bits of that register rotate. The output pin is fed from a flip-flop, so it cannot glitch. To use the block, the host first loads a pattern word and a length while `enable` is low. It then raises `enable` with an increment. A one-cycle strobe marks each new bit so that other logic can follow the stream.

Top module: `frac_pattern_gen`

## Requirements
- R1: After synchronous reset, `serialOut` and `bitAdv` are 0, the phase accumulator is zero, and the held pattern is all zeros.
- R2: If `load` is high while `enable` is low, the following cycle does all of these: it latches `patternIn` and the clamped length, clears the accumulator, shows `patternIn[31]` on `serialOut`, and keeps `bitAdv` at 0.
- R3: While `enable` is high, `load` has no effect. The current pattern, length and accumulator carry on unchanged.
- R4: While enabled, the 16.16 `increment` is added to a 16-bit fractional phase every cycle. A carry past 1.0 causes an advance. On the edge after an advance, `serialOut` shows the new bit and `bitAdv` is high for that single cycle.
- R5: The pattern occupies bits 31 down to 32-L of the loaded word and is sent MSB first. Each advance rotates those L bits up by one, and bit 31 wraps to bit 32-L. With L=10 and pattern 0b0100110011, the stream is 0,1,0,0,1,1,0,0,1,1 repeating.
- R6: An increment of 1.0 (0x0001_0000) advances on every enabled cycle. An increment of 0.5 (0x0000_8000) advances on every second enabled cycle, starting with the second cycle after a load.
- R7: An increment above 1.0 is treated as 1.0, giving one advance per enabled cycle.
- R8: With a fractional increment f (in units of 1/65536) after a load, the number of advances in N enabled cycles is floor(N*f/65536).
- R9: While `enable` is low and `load` is low, the accumulator and the pattern hold, `serialOut` keeps its value, and `bitAdv` is 0.
- R10: A `lengthIn` of 0 is treated as 1, and a value above 32 is treated as 32. With L=1 the output stays at the loaded bit 31.
- R11: An increment of zero never advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the accumulator and rotate the pattern |
| load | input | 1 | Pattern load strobe; only acted on while `enable` is low |
| patternIn | input | 32 | Pattern word, left aligned, first bit in bit 31 |
| lengthIn | input | 6 | Pattern length in bits, 1 to 32 |
| increment | input | 32 | 16.16 phase step per clock |
| serialOut | output | 1 | Registered serial output |
| bitAdv | output | 1 | One-cycle strobe on each bit advance |

## Verification
If the accumulator holds a wrong phase, the first visible symptom is `bitAdv` firing in the wrong cycle. That shows up within one carry period, which is at most 65536 cycles for the smallest step and two cycles at a step of 0.5. A wrong rotation or wrap position shows up as a wrong bit on `serialOut` within L advances of the load, because a full pattern pass exposes every position. A load that was not honoured, or was wrongly honoured, shows on the very next cycle's output bit. The reference model tracks the pattern as a queue of bits and the phase as an integer, and compares both outputs on every clock.

// File: rtl/frac_pattern_gen_pkg.sv
package frac_pattern_gen_pkg;
  typedef struct packed {
    logic load;
    logic adv;
  } pgStrobe_t;
endpackage

// File: rtl/frac_pattern_gen_ctrl.sv
module frac_pattern_gen_ctrl
  import frac_pattern_gen_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    load,
  input  logic [INT_W+FRAC_W-1:0] increment,
  output pgStrobe_t               strobes
);
  localparam int INC_W = INT_W + FRAC_W;
  localparam logic [INC_W-1:0] ONE = INC_W'(1) << FRAC_W;

  logic [FRAC_W-1:0] phaseAcc;
  logic [FRAC_W:0]   stepEff;
  logic [FRAC_W:0]   phaseSum;
  logic              carryOut;

  // Clip the step at exactly one unit so no more than one advance per cycle.
  always_comb begin
    if (increment >= ONE) stepEff = {1'b1, {FRAC_W{1'b0}}};
    else                  stepEff = {1'b0, increment[FRAC_W-1:0]};
    phaseSum = {1'b0, phaseAcc} + stepEff;
    carryOut = phaseSum[FRAC_W];
  end

  always_comb begin
    strobes.load = load && !enable;
    strobes.adv  = enable && carryOut;
  end

  always_ff @(posedge clk) begin
    if (rst)               phaseAcc <= '0;
    else if (strobes.load) phaseAcc <= '0;
    else if (enable)       phaseAcc <= phaseSum[FRAC_W-1:0];
  end

  AST_ACC_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && !enable) |=> (phaseAcc == '0)); // R2

  AST_ACC_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!enable && !load) |=> $stable(phaseAcc)); // R9

  AST_LOAD_IGNORED_RUN: assert property (@(posedge clk) disable iff (rst)
    enable |-> !strobes.load); // R3

  AST_ZERO_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (enable && increment == '0) |=> $stable(phaseAcc)); // R11
endmodule

// File: rtl/frac_pattern_gen_datapath.sv
module frac_pattern_gen_datapath
  import frac_pattern_gen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  pgStrobe_t         strobes,
  input  logic [DATA_W-1:0] patternIn,
  input  logic [LEN_W-1:0]  lengthIn,
  output logic              serialOut,
  output logic              bitAdv
);
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] rotated;
  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  lenClamped;
  int                wrapPos;

  always_comb begin
    if (lengthIn == '0)                lenClamped = LEN_W'(1);
    else if (int'(lengthIn) > DATA_W)  lenClamped = LEN_W'(DATA_W);
    else                               lenClamped = lengthIn;
    wrapPos = DATA_W - int'(lenReg);
  end

  // Rotate only the active top window; lower bits stay put.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rot
    if (i == 0) begin : g_low
      always_comb rotated[i] = (wrapPos == 0) ? shiftReg[DATA_W-1] : shiftReg[i];
    end else begin : g_up
      always_comb begin
        if (i == wrapPos)     rotated[i] = shiftReg[DATA_W-1];
        else if (i > wrapPos) rotated[i] = shiftReg[i-1];
        else                  rotated[i] = shiftReg[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      lenReg    <= LEN_W'(DATA_W);
      serialOut <= 1'b0;
      bitAdv    <= 1'b0;
    end else if (strobes.load) begin
      shiftReg  <= patternIn;
      lenReg    <= lenClamped;
      serialOut <= patternIn[DATA_W-1];
      bitAdv    <= 1'b0;
    end else if (strobes.adv) begin
      shiftReg  <= rotated;
      serialOut <= rotated[DATA_W-1];
      bitAdv    <= 1'b1;
    end else begin
      bitAdv    <= 1'b0;
    end
  end

  AST_LOAD_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (serialOut == $past(patternIn[DATA_W-1]) && !bitAdv)); // R2

  AST_ADV_STROBE: assert property (@(posedge clk) disable iff (rst)
    strobes.adv |=> bitAdv); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobes.adv && !strobes.load) |=> ($stable(serialOut) && !bitAdv)); // R9

  AST_ROTATE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (strobes.adv && lenReg >= LEN_W'(2)) |=> (serialOut == $past(shiftReg[DATA_W-2]))); // R5

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (lenReg >= LEN_W'(1) && int'(lenReg) <= DATA_W)); // R10
endmodule

// File: rtl/frac_pattern_gen.sv
module frac_pattern_gen
  import frac_pattern_gen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int LEN_W  = $clog2(DATA_W) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    load,
  input  logic [DATA_W-1:0]       patternIn,
  input  logic [LEN_W-1:0]        lengthIn,
  input  logic [INT_W+FRAC_W-1:0] increment,
  output logic                    serialOut,
  output logic                    bitAdv
);
  pgStrobe_t strobes;

  frac_pattern_gen_ctrl #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .load     (load),
    .increment(increment),
    .strobes  (strobes)
  );

  frac_pattern_gen_datapath #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .patternIn(patternIn),
    .lengthIn (lengthIn),
    .serialOut(serialOut),
    .bitAdv   (bitAdv)
  );
endmodule

// File: tb/frac_pattern_gen_test.sv
`timescale 1ns/1ps
module frac_pattern_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        load = 1'b0;
  logic [31:0] patternIn = '0;
  logic [5:0]  lengthIn = 6'd32;
  logic [31:0] increment = '0;
  logic        serialOut;
  logic        bitAdv;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference
  bit modelQ[$];
  int modelAcc = 0;
  bit modelOut = 0;
  bit modelAdv = 0;

  always #10 clk = ~clk;

  frac_pattern_gen uut (
    .clk(clk), .rst(rst), .enable(enable), .load(load),
    .patternIn(patternIn), .lengthIn(lengthIn), .increment(increment),
    .serialOut(serialOut), .bitAdv(bitAdv)
  );

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      modelQ.delete();
      for (int k = 0; k < 32; k++) modelQ.push_back(1'b0);
      modelAcc = 0; modelOut = 0; modelAdv = 0;
    end else if (load && !enable) begin
      int len;
      len = (lengthIn == 0) ? 1 : ((lengthIn > 32) ? 32 : int'(lengthIn));
      modelQ.delete();
      for (int k = 0; k < len; k++) modelQ.push_back(patternIn[31-k]);
      modelAcc = 0; modelOut = modelQ[0]; modelAdv = 0;
    end else if (enable) begin
      int step;
      bit b;
      step = (increment > 32'h0001_0000) ? 65536 : int'(increment);
      modelAcc += step;
      if (modelAcc >= 65536) begin
        modelAcc -= 65536;
        b = modelQ.pop_front();
        modelQ.push_back(b);
        modelOut = modelQ[0];
        modelAdv = 1;
      end else modelAdv = 0;
    end else modelAdv = 0;
  end

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  int advSeen = 0;
  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      load = 1'b0;
      check(curReq, serialOut, modelOut, "serialOut");
      check(curReq, bitAdv, modelAdv, "bitAdv");
      if (bitAdv) advSeen++;
    end
  endtask

  task automatic doLoad(logic [31:0] pat, logic [5:0] len);
    @(negedge clk);
    enable = 1'b0; load = 1'b1; patternIn = pat; lengthIn = len;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    curReq = "R1";
    step(2);

    // R2 and R5: ten-bit example, MSB first at one bit per cycle (R6)
    curReq = "R2";
    doLoad({10'b0100110011, 22'd0}, 6'd10);
    step(1);
    check("R2", serialOut, 1'b0, "first bit after load");
    curReq = "R5";
    increment = 32'h0001_0000;
    enable = 1'b1;
    advSeen = 0;
    step(25);
    check("R6", logic'(advSeen == 25), 1'b1, "advance every cycle at 1.0");

    // R9 hold while idle
    curReq = "R9";
    enable = 1'b0;
    increment = 32'h0000_4000;
    advSeen = 0;
    step(6);
    check("R9", logic'(advSeen == 0), 1'b1, "no advance while disabled");

    // R3 load while enabled is ignored
    curReq = "R3";
    @(negedge clk);
    enable = 1'b1; load = 1'b1; patternIn = 32'hFFFF_FFFF; lengthIn = 6'd3;
    increment = 32'h0001_0000;
    step(12);

    // R6 half rate
    curReq = "R6";
    doLoad(32'hF0F0_1234, 6'd32);
    step(1);
    enable = 1'b1; increment = 32'h0000_8000;
    advSeen = 0;
    step(20);
    check("R6", logic'(advSeen == 10), 1'b1, "half-rate advance count");

    // R8 fractional step
    curReq = "R8";
    doLoad(32'hA5C3_0000, 6'd16);
    step(1);
    enable = 1'b1; increment = 32'h0000_5555;
    advSeen = 0;
    step(60);
    check("R8", logic'(advSeen == (60 * 32'h5555) / 65536), 1'b1, "fractional advance count");

    // R7 saturation
    curReq = "R7";
    increment = 32'h0003_0000;
    advSeen = 0;
    step(20);
    check("R7", logic'(advSeen == 20), 1'b1, "saturated advance count");

    // R11 zero step
    curReq = "R11";
    increment = 32'h0;
    advSeen = 0;
    step(10);
    check("R11", logic'(advSeen == 0), 1'b1, "no advance at zero step");

    // R10 length clamps
    curReq = "R10";
    doLoad(32'h8000_0000, 6'd0);
    step(1);
    enable = 1'b1; increment = 32'h0001_0000;
    step(8);
    check("R10", serialOut, 1'b1, "length 0 acts as 1");
    doLoad(32'h8000_0001, 6'd40);
    step(1);
    enable = 1'b1;
    step(40);

    // R4 fractional near one
    curReq = "R4";
    doLoad({10'b0100110011, 22'd0}, 6'd10);
    step(1);
    enable = 1'b1; increment = 32'h0000_E000;
    step(40);

    finishRun();
  end
endmodule